// File: doc/BRIEF.md
# Striped Flash Address Translator

This block turns a logical location in a flash array that stripes bytes over four channels into a physical location. The physical location is a channel, chip half, plane, physical block, page and column. A request carries a logical block number, a page index inside that block and a byte offset inside the 64 KB logical page. The channel is taken from the two lowest offset bits, so each channel holds every fourth byte. The rest of the offset divided by four picks one of four 4 KB per-chip pages: upper half plane 0, upper half plane 1, lower half plane 0, lower half plane 1, in that order.

Physical blocks pair neighbours for two-plane use: the even block is plane 0 and the odd block is plane 1. The lower half of the chip sits at a fixed block distance from the upper half. Every channel has its own substitution table. A failing logical block on one channel can be sent to a spare on that channel alone, while the other channels keep the original number. The table is looked up before the plane and half offsets are added.

Requests use a valid/ready handshake and give one registered result record after one cycle. Tables are loaded through a write-only configuration port.

Top module: `stripe_addr_xlate`

## Requirements
- R1: The output lane equals the request byte offset modulo 4.
- R2: With q = offset / 4, the column is q mod 4096, the plane is bit 12 of q and the half is bit 13 of q (0 = upper, 1 = lower).
- R3: With no substitution, the block is 2*L + plane for the upper half and HALF_OFS + 2*L + plane for the lower half, where L is the logical block number and HALF_OFS defaults to 2048.
- R4: A valid table entry on lane c whose original equals L replaces L by its spare, only for requests that resolve to lane c. The plane and half offsets are then added to the spare.
- R5: An entry written with its valid bit at 0 has no effect. Rewriting an entry with valid 0 removes an earlier substitution.
- R6: When several valid entries of one lane match, the entry with the lowest index supplies the spare.
- R7: The output page equals the request page index.
- R8: A byte offset of 65536 or more gives a record with the error flag set and all location fields zero.
- R9: A logical block number of NUM_LBLK (default 1000) or more gives a record with the error flag set and all location fields zero.
- R10: A request accepted on a clock edge appears on the outputs after that edge. in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the record stays unchanged.
- R11: After reset, out_valid is low, in_ready is high and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_lblk | input | 10 | Logical block number |
| in_page | input | 7 | Page index inside the logical block |
| in_ofs | input | 17 | Byte offset inside the logical page |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Consumer takes the record |
| out_err | output | 1 | Request was out of range |
| out_lane | output | 2 | Channel |
| out_half | output | 1 | Chip half |
| out_plane | output | 1 | Plane |
| out_blk | output | 12 | Physical block |
| out_page | output | 7 | Page in block |
| out_col | output | 12 | Byte column in per-chip page |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_lane | input | 2 | Lane whose table is written |
| cfg_idx | input | 4 | Entry index |
| cfg_vld | input | 1 | Entry valid bit |
| cfg_orig | input | 10 | Logical block replaced |
| cfg_spare | input | 10 | Spare logical block |

## Verification
The assertions check the handshake on every cycle: a record appears after each accepted request, a stalled record holds, and in_ready follows the stall rule. They also check the lane of each accepted offset, the error flag for out-of-range offsets and blocks, zeroed fields on errors, and the fixed link between plane, half and block number. Only the bench scenarios can show the full arithmetic of column and block over a sweep of offsets, lane-local substitution, lowest-index priority, and the removal of entries by rewriting them invalid.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  // order of 4 KB per-chip pages inside one lane's 16 KB share
  typedef enum logic [1:0] {
    SEG_UP_P0  = 2'd0,
    SEG_UP_P1  = 2'd1,
    SEG_LOW_P0 = 2'd2,
    SEG_LOW_P1 = 2'd3
  } seg_e;

  function automatic logic seg_half(input seg_e s);
    return (s == SEG_LOW_P0) || (s == SEG_LOW_P1);
  endfunction

  function automatic logic seg_plane(input seg_e s);
    return (s == SEG_UP_P1) || (s == SEG_LOW_P1);
  endfunction
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int DEPTH = 16,
  parameter int LB_W  = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_vld,
  input  logic [LB_W-1:0]  wr_orig,
  input  logic [LB_W-1:0]  wr_spare,
  input  logic [LB_W-1:0]  lk_blk,
  output logic [LB_W-1:0]  lk_out
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [LB_W-1:0]  orig_q  [DEPTH];
  logic [LB_W-1:0]  spare_q [DEPTH];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = wr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic ent_we;
      assign ent_we = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (ent_we) begin
          orig_q[i]  <= wr_orig;
          spare_q[i] <= wr_spare;
        end
      end
    end
  endgenerate

  // parallel compare, lowest index wins
  always_comb begin
    lk_out = lk_blk;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && (orig_q[i] == lk_blk)) lk_out = spare_q[i];
    end
  end
endmodule

// File: rtl/offset_split.sv
module offset_split
  import xlt_pkg::*;
#(
  parameter int LANE_W = 2,
  parameter int COL_W  = 12,
  localparam int OFS_W = LANE_W + COL_W + 3
) (
  input  logic [OFS_W-1:0] ofs,
  output logic [LANE_W-1:0] lane,
  output logic             half,
  output logic             plane,
  output logic [COL_W-1:0] col,
  output logic             over
);
  seg_e seg;
  assign lane  = ofs[LANE_W-1:0];
  assign col   = ofs[LANE_W +: COL_W];
  assign seg   = seg_e'(ofs[LANE_W+COL_W +: 2]);
  assign half  = seg_half(seg);
  assign plane = seg_plane(seg);
  assign over  = ofs[OFS_W-1];
endmodule

// File: rtl/stripe_addr_xlate.sv
module stripe_addr_xlate #(
  parameter int LANES       = 4,
  parameter int PAGE_BYTES  = 4096,
  parameter int LB_W        = 10,
  parameter int PB_W        = 12,
  parameter int PG_W        = 7,
  parameter int REMAP_DEPTH = 16,
  parameter int NUM_LBLK    = 1000,
  parameter int HALF_OFS    = 2048,
  localparam int LANE_W = $clog2(LANES),
  localparam int COL_W  = $clog2(PAGE_BYTES),
  localparam int OFS_W  = LANE_W + COL_W + 3,
  localparam int IDX_W  = $clog2(REMAP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LB_W-1:0]   in_lblk,
  input  logic [PG_W-1:0]   in_page,
  input  logic [OFS_W-1:0]  in_ofs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_err,
  output logic [LANE_W-1:0] out_lane,
  output logic              out_half,
  output logic              out_plane,
  output logic [PB_W-1:0]   out_blk,
  output logic [PG_W-1:0]   out_page,
  output logic [COL_W-1:0]  out_col,
  input  logic              cfg_we,
  input  logic [LANE_W-1:0] cfg_lane,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_vld,
  input  logic [LB_W-1:0]   cfg_orig,
  input  logic [LB_W-1:0]   cfg_spare
);
  localparam logic [LB_W:0] BLK_LIM = (LB_W+1)'(NUM_LBLK);
  localparam logic [PB_W-1:0] HALF_STEP = PB_W'(HALF_OFS);

  // offset decomposition
  logic [LANE_W-1:0] s_lane;
  logic              s_half, s_plane, s_over;
  logic [COL_W-1:0]  s_col;

  offset_split #(.LANE_W(LANE_W), .COL_W(COL_W)) u_split (
    .ofs(in_ofs), .lane(s_lane), .half(s_half), .plane(s_plane),
    .col(s_col), .over(s_over)
  );

  // per-lane substitution tables
  logic [LB_W-1:0] tbl_out [LANES];

  generate
    for (genvar c = 0; c < LANES; c++) begin : g_lane
      logic lane_we;
      assign lane_we = cfg_we && (cfg_lane == LANE_W'(c));
      remap_table #(.DEPTH(REMAP_DEPTH), .LB_W(LB_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lane_we), .wr_idx(cfg_idx), .wr_vld(cfg_vld),
        .wr_orig(cfg_orig), .wr_spare(cfg_spare),
        .lk_blk(in_lblk), .lk_out(tbl_out[c])
      );
    end
  endgenerate

  // translation
  logic            s_range_bad, s_err;
  logic [LB_W-1:0] s_mapped;
  logic [PB_W-1:0] s_blk;

  assign s_range_bad = ({1'b0, in_lblk} >= BLK_LIM);
  assign s_err       = s_over || s_range_bad;
  assign s_mapped    = tbl_out[s_lane];
  assign s_blk       = PB_W'({s_mapped, s_plane}) + (s_half ? HALF_STEP : '0);

  // handshake and output register
  logic accept;
  logic vld_q, vld_d;
  logic              err_d;
  logic [LANE_W-1:0] lane_d;
  logic              half_d, plane_d;
  logic [PB_W-1:0]   blk_d;
  logic [PG_W-1:0]   page_d;
  logic [COL_W-1:0]  col_d;

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (accept)         vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_comb begin
    err_d   = s_err;
    lane_d  = '0;
    half_d  = 1'b0;
    plane_d = 1'b0;
    blk_d   = '0;
    page_d  = '0;
    col_d   = '0;
    if (!s_err) begin
      lane_d  = s_lane;
      half_d  = s_half;
      plane_d = s_plane;
      blk_d   = s_blk;
      page_d  = in_page;
      col_d   = s_col;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_err   <= err_d;
      out_lane  <= lane_d;
      out_half  <= half_d;
      out_plane <= plane_d;
      out_blk   <= blk_d;
      out_page  <= page_d;
      out_col   <= col_d;
    end
  end

  assign out_valid = vld_q;
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
  parameter int LANE_W   = 2,
  parameter int COL_W    = 12,
  parameter int OFS_W    = 17,
  parameter int LB_W     = 10,
  parameter int PB_W     = 12,
  parameter int PG_W     = 7,
  parameter int NUM_LBLK = 1000,
  parameter int HALF_OFS = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [LB_W-1:0]   in_lblk,
  input logic [OFS_W-1:0]  in_ofs,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_err,
  input logic [LANE_W-1:0] out_lane,
  input logic              out_half,
  input logic              out_plane,
  input logic [PB_W-1:0]   out_blk,
  input logic [PG_W-1:0]   out_page,
  input logic [COL_W-1:0]  out_col
);
  localparam int LPAGE = 1 << (OFS_W - 1);
  logic take;
  assign take = in_valid && in_ready;

  // R10
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_err, out_lane, out_half, out_plane, out_blk, out_page, out_col})));

  // R10
  rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (out_err || out_lane == $past(in_ofs[LANE_W-1:0])));

  // R8
  over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (32'(in_ofs) >= LPAGE)) |=> out_err);

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (32'(in_lblk) >= NUM_LBLK)) |=> out_err);

  // R8
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |->
      ({out_lane, out_half, out_plane, out_blk, out_page, out_col} == '0));

  // R3
  plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |->
      (out_blk[0] == out_plane && out_half == (32'(out_blk) >= HALF_OFS)));
endmodule

bind stripe_addr_xlate xlt_chk #(
  .LANE_W(LANE_W), .COL_W(COL_W), .OFS_W(OFS_W), .LB_W(LB_W), .PB_W(PB_W),
  .PG_W(PG_W), .NUM_LBLK(NUM_LBLK), .HALF_OFS(HALF_OFS)
) u_xlt_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_lblk(in_lblk), .in_ofs(in_ofs), .out_valid(out_valid),
  .out_ready(out_ready), .out_err(out_err), .out_lane(out_lane),
  .out_half(out_half), .out_plane(out_plane), .out_blk(out_blk),
  .out_page(out_page), .out_col(out_col)
);

// File: tb/test_stripe_addr_xlate.sv
module test_stripe_addr_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [9:0]  in_lblk;
  logic [6:0]  in_page;
  logic [16:0] in_ofs;
  logic        out_valid, out_ready, out_err;
  logic [1:0]  out_lane;
  logic        out_half, out_plane;
  logic [11:0] out_blk;
  logic [6:0]  out_page;
  logic [11:0] out_col;
  logic        cfg_we;
  logic [1:0]  cfg_lane;
  logic [3:0]  cfg_idx;
  logic        cfg_vld;
  logic [9:0]  cfg_orig, cfg_spare;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 0;

  // bench model of the tables
  bit mvld [4][16];
  int morig [4][16];
  int mspare [4][16];

  always #4 clk = ~clk;

  stripe_addr_xlate i_stripe_addr_xlate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lblk(in_lblk), .in_page(in_page), .in_ofs(in_ofs),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err),
    .out_lane(out_lane), .out_half(out_half), .out_plane(out_plane),
    .out_blk(out_blk), .out_page(out_page), .out_col(out_col),
    .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_idx(cfg_idx),
    .cfg_vld(cfg_vld), .cfg_orig(cfg_orig), .cfg_spare(cfg_spare)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_map(input int lane, input int lb);
    for (int i = 0; i < 16; i++)
      if (mvld[lane][i] && morig[lane][i] == lb) return mspare[lane][i];
    return lb;
  endfunction

  task automatic cfg_write(input int lane, input int idx, input bit v, input int orig, input int spare);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lane = 2'(lane); cfg_idx = 4'(idx);
    cfg_vld = v; cfg_orig = 10'(orig); cfg_spare = 10'(spare);
    @(negedge clk);
    cfg_we = 1'b0;
    mvld[lane][idx] = v; morig[lane][idx] = orig; mspare[lane][idx] = spare;
  endtask

  task automatic check_out(input int lb, input int pg, input int ofs, input string btag);
    bit e;
    int q, lane, half, plane, col, blk;
    e = (ofs >= 65536) || (lb >= 1000);
    lane = ofs % 4; q = ofs / 4;
    col = q % 4096; plane = (q / 4096) % 2; half = (q / 8192) % 2;
    blk = 2 * model_map(lane, lb) + plane + half * 2048;
    chk(out_valid == 1'b1, "R10", out_valid, 1);
    if (e) begin
      chk(out_err == 1'b1, (lb >= 1000) ? "R9" : "R8", out_err, 1);
      chk({out_lane, out_half, out_plane, out_blk, out_page, out_col} == '0,
          (lb >= 1000) ? "R9" : "R8", out_blk, 0);
    end else begin
      chk(out_err == 1'b0, "R8", out_err, 0);
      chk(int'(out_lane) == lane, "R1", out_lane, lane);
      chk(int'(out_col) == col, "R2", out_col, col);
      chk(int'(out_plane) == plane && int'(out_half) == half, "R2",
          {out_half, out_plane}, half * 2 + plane);
      chk(int'(out_blk) == blk, btag, out_blk, blk);
      chk(int'(out_page) == pg, "R7", out_page, pg);
    end
  endtask

  task automatic req(input int lb, input int pg, input int ofs, input string btag);
    @(negedge clk);
    in_valid = 1'b1; in_lblk = 10'(lb); in_page = 7'(pg); in_ofs = 17'(ofs);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(lb, pg, ofs, btag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_lblk = '0; in_page = '0; in_ofs = '0;
    out_ready = 1'b1; cfg_we = 1'b0; cfg_lane = '0; cfg_idx = '0;
    cfg_vld = 1'b0; cfg_orig = '0; cfg_spare = '0;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 16; i++) begin
        mvld[c][i] = 0; morig[c][i] = 0; mspare[c][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", out_valid, 0);
    chk(in_ready == 1'b1, "R11", in_ready, 1);

    // R11: empty tables, every lane passes the block through
    for (int o = 0; o < 8; o++) req(0, 0, o, "R11");

    // R1 R2 R3 R7 sweep over the logical page
    for (int o = 0; o < 65536; o += 5) req(37, o % 128, o, "R3");
    req(999, 127, 65535, "R3");
    req(0, 0, 16383, "R3");
    req(1, 3, 32768, "R3");

    // R4 substitution only on lane 2
    cfg_write(2, 0, 1'b1, 37, 900);
    for (int o = 0; o < 8; o++) req(37, 1, o, "R4");
    req(37, 1, 2 + 4 * 8192 + 4 * 4096, "R4");

    // R6 lower index wins
    cfg_write(2, 3, 1'b1, 37, 950);
    req(37, 2, 2, "R6");
    req(37, 2, 6 + 4 * 8192, "R6");

    // R5 removal and invalid writes
    cfg_write(2, 0, 1'b0, 37, 900);
    req(37, 2, 2, "R5");
    cfg_write(1, 5, 1'b0, 40, 700);
    req(40, 0, 1, "R5");
    req(40, 0, 5 + 4 * 4096, "R5");

    // R8 R9 range errors
    req(10, 0, 65536, "R8");
    req(10, 0, 131071, "R8");
    req(1000, 0, 0, "R9");
    req(1023, 5, 100, "R9");

    // R10 stall
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_lblk = 10'd12; in_page = 7'd9; in_ofs = 17'd3;
    @(negedge clk);
    in_lblk = 10'd13; in_page = 7'd4; in_ofs = 17'd1;
    chk(in_ready == 1'b0, "R10", in_ready, 0);
    check_out(12, 9, 3, "R10");
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R10", in_ready, 0);
    check_out(12, 9, 3, "R10");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(13, 4, 1, "R10");
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", out_valid, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule